// File: doc/BRIEF.md
# Core reset and fault-halt sequencer

This control block brings a 32-bit processor core out of reset and stops it for good when one fault arrives while another is still being handled. A synchronous reset aborts whatever is running and puts the status-register fields and the control registers into their power-up values. The block then waits until it owns the bus. It fetches the initial stack pointer and the initial program counter from the first two longwords of the vector table, and then lets the core fetch its first instruction from the loaded program counter.

While the core runs, a fault input opens exception processing. A handler-start pulse closes it again. If a second fault arrives while exception processing is open, the block enters a halt state. The reset vector fetch counts as exception processing for this purpose. In the halt state it drives the 4-bit processor-status code 4'hF. Only reset leaves that state.

Top module: `core_reset_seq`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `fetch_en`=0, `rd_req`=0 and `pst`=4'hC, whatever the previous state was, including halt.
- R2: After reset the status fields read `sr_super`=1, `sr_trace`=0, `sr_master`=0 and `sr_ipl`=3'd7.
- R3: After reset `vbr`=0, `cache_en`=0 and `sram_en`=0.
- R4: `rd_req` is high only in cycles where `bus_grant`=1 and `bus_alt_busy`=0. No vector read starts while the bus is not granted or another master holds it.
- R5: The first vector read uses address `vbr`+0, and its data appears on `sp_out`. The second read uses `vbr`+4, and its data becomes the program counter. Data is taken in the cycle where `rd_req` and `rd_ack` are both high.
- R6: While `rd_req` is high and `rd_ack` is low, `rd_addr` holds its value into the next cycle.
- R7: In the cycle after the second read is acknowledged, `fetch_en`=1, `fetch_addr` equals the loaded program counter and `pst`=4'h0.
- R8: If the grant is lost, or `bus_alt_busy` rises, before a read is acknowledged, then `rd_req` drops and no register is loaded. When the grant returns, the same pending read is issued again at the same address.
- R9: A `fault` pulse while running gives `fetch_en`=0 and `pst`=4'hC from the next cycle on. A later `handler_start` pulse returns the block to `fetch_en`=1.
- R10: A `fault` during exception processing gives `pst`=4'hF, `fetch_en`=0 and `rd_req`=0 from the next cycle on, and this happens even if `handler_start` arrives in the same cycle. These values then hold whatever the inputs do, until reset.
- R11: A `fault` at any point between reset and the end of the vector fetch also leads to the halt state of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Bus ownership granted to the core |
| bus_alt_busy | input | 1 | Another master is taking the bus |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | XLEN | Vector read address |
| rd_ack | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data | input | XLEN | Read data |
| fault | input | 1 | Fault detected by the core |
| handler_start | input | 1 | Exception handler has begun; processing complete |
| fetch_en | output | 1 | Core may fetch instructions |
| fetch_addr | output | XLEN | Address of the first instruction fetch |
| sp_out | output | XLEN | Loaded initial stack pointer |
| sr_super | output | 1 | Supervisor status bit |
| sr_trace | output | 1 | Trace status bit |
| sr_master | output | 1 | Master status bit |
| sr_ipl | output | 3 | Interrupt priority mask |
| vbr | output | XLEN | Vector base |
| cache_en | output | 1 | Cache enable from control registers |
| sram_en | output | 1 | On-chip RAM enable |
| pst | output | 4 | Processor-status code |

## Verification
The assertions assume that `rd_ack` has meaning only while `rd_req` is high. They also assume that `handler_start` comes only after a fault has opened exception processing, and that `rst` is high at the first clock edge. The bench's memory model raises `rd_ack` only after it has seen `rd_req` at its address, and holds it for one cycle. Handler-start pulses are applied in the exception state in every case except the one deliberate collision with a nested fault. Faults, grant loss and random latencies are placed only in the read and run phases the requirements describe. In the halt phase the bench uses random inputs only on purpose.

// File: rtl/core_reset_seq.sv
module core_reset_seq #(
  parameter int XLEN = 32,
  parameter int IPL_W = 3,
  parameter int VEC_BYTES = 4,
  parameter logic [3:0] PST_RUN = 4'h0,
  parameter logic [3:0] PST_EXC = 4'hC,
  parameter logic [3:0] PST_HALT = 4'hF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_grant,
  input  logic            bus_alt_busy,
  output logic            rd_req,
  output logic [XLEN-1:0] rd_addr,
  input  logic            rd_ack,
  input  logic [XLEN-1:0] rd_data,
  input  logic            fault,
  input  logic            handler_start,
  output logic            fetch_en,
  output logic [XLEN-1:0] fetch_addr,
  output logic [XLEN-1:0] sp_out,
  output logic            sr_super,
  output logic            sr_trace,
  output logic            sr_master,
  output logic [IPL_W-1:0] sr_ipl,
  output logic [XLEN-1:0] vbr,
  output logic            cache_en,
  output logic            sram_en,
  output logic [3:0]      pst
);
  localparam logic [XLEN-1:0] VBR_RST = '0;
  localparam logic [XLEN-1:0] PC_OFS = XLEN'(VEC_BYTES);
  localparam logic [IPL_W-1:0] IPL_TOP = '1;

  typedef enum logic [2:0] {
    S_INIT, S_WAIT, S_RDSP, S_RDPC, S_RUN, S_EXC, S_HALT
  } st_t;

  st_t state;
  logic pc_phase, exc_active;
  logic [XLEN-1:0] sp_q, pc_q, vbr_q;
  logic grant_ok, in_read, halted, take;

  assign grant_ok = bus_grant && !bus_alt_busy;
  assign in_read  = (state == S_RDSP) || (state == S_RDPC);
  assign halted   = (state == S_HALT);
  assign rd_req   = in_read && grant_ok;
  assign take     = rd_req && rd_ack;
  assign rd_addr  = (state == S_RDPC) ? vbr_q + PC_OFS : vbr_q;
  assign fetch_en = (state == S_RUN);
  assign fetch_addr = pc_q;
  assign sp_out   = sp_q;
  assign vbr      = vbr_q;
  assign pst      = halted ? PST_HALT : (exc_active ? PST_EXC : PST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_super  <= 1'b1;
      sr_trace  <= 1'b0;
      sr_master <= 1'b0;
      sr_ipl    <= IPL_TOP;
      vbr_q     <= VBR_RST;
      cache_en  <= 1'b0;
      sram_en   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_INIT;
      pc_phase   <= 1'b0;
      exc_active <= 1'b1;
      sp_q       <= '0;
      pc_q       <= '0;
    end else if (!halted) begin
      if (fault && exc_active) begin
        state <= S_HALT;
      end else begin
        case (state)
          S_INIT: state <= S_WAIT;
          S_WAIT: if (grant_ok) state <= pc_phase ? S_RDPC : S_RDSP;
          S_RDSP, S_RDPC: begin
            if (take) begin
              if (state == S_RDSP) begin
                sp_q     <= rd_data;
                pc_phase <= 1'b1;
                state    <= S_RDPC;
              end else begin
                pc_q       <= rd_data;
                exc_active <= 1'b0;
                state      <= S_RUN;
              end
            end else if (!grant_ok) begin
              state <= S_WAIT;
            end
          end
          S_RUN: if (fault) begin
            exc_active <= 1'b1;
            state      <= S_EXC;
          end
          S_EXC: if (handler_start) begin
            exc_active <= 1'b0;
            state      <= S_RUN;
          end
          default: state <= S_HALT;
        endcase
      end
    end
  end

  a_r2_sr_after_reset: assert property (@(posedge clk)
    rst |=> (sr_super && !sr_trace && !sr_master && sr_ipl == IPL_TOP));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (!rd_req || $stable(rd_addr)));

  a_r7_run_after_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_en) |-> ($past(take) || $past(handler_start)));

  a_r9_fault_stops: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && fault) |=> (!fetch_en && pst == PST_EXC));

  a_r10_nested_halts: assert property (@(posedge clk) disable iff (rst)
    (fault && exc_active) |=> (pst == PST_HALT && !fetch_en && !rd_req));

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
endmodule

// File: tb/tb_core_reset_seq.sv
module tb_core_reset_seq;
  localparam time PERIOD = 4ns;
  logic clk = 1'b0;
  logic rst, bus_grant, bus_alt_busy, rd_ack, fault, handler_start;
  logic [31:0] rd_data;
  logic rd_req, fetch_en, sr_super, sr_trace, sr_master, cache_en, sram_en;
  logic [31:0] rd_addr, fetch_addr, sp_out, vbr;
  logic [2:0] sr_ipl;
  logic [3:0] pst;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  core_reset_seq dut (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .bus_alt_busy(bus_alt_busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .fault(fault), .handler_start(handler_start), .fetch_en(fetch_en),
    .fetch_addr(fetch_addr), .sp_out(sp_out), .sr_super(sr_super),
    .sr_trace(sr_trace), .sr_master(sr_master), .sr_ipl(sr_ipl), .vbr(vbr),
    .cache_en(cache_en), .sram_en(sram_en), .pst(pst));

  function automatic logic [31:0] vec_addr(input int idx);
    return 32'(idx * 4);
  endfunction

  function automatic logic [3:0] exp_pst(input bit halt, input bit exc);
    return halt ? 4'hF : (exc ? 4'hC : 4'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; bus_grant = 0; bus_alt_busy = 0; rd_ack = 0; rd_data = '0;
    fault = 0; handler_start = 0;
    cyc(); cyc();
    chk(fetch_en == 0 && rd_req == 0, "R1", "idle in reset", {fetch_en, rd_req}, 0);
    chk(pst == exp_pst(0, 1), "R1", "pst in reset", pst, exp_pst(0, 1));
    chk(sr_super && !sr_trace && !sr_master && sr_ipl == 3'd7, "R2", "status fields",
        {sr_super, sr_trace, sr_master, sr_ipl}, 6'b100111);
    chk(vbr == 0 && !cache_en && !sram_en, "R3", "control regs", {vbr[29:0], cache_en, sram_en}, 0);
    rst = 0;
  endtask

  task automatic serve(input logic [31:0] exp_a, input logic [31:0] data, input int lat);
    logic [31:0] a0;
    int n = 0;
    #1;
    while (!rd_req && n < 100) begin cyc(); #1; n++; end
    chk(rd_req, "R4", "request seen", rd_req, 1);
    chk(rd_addr == exp_a, "R5", "vector address", rd_addr, exp_a);
    a0 = rd_addr;
    for (int k = 0; k < lat; k++) begin
      cyc(); #1;
      chk(rd_req && rd_addr == a0, "R6", "address held", rd_addr, a0);
    end
    rd_ack = 1; rd_data = data;
    cyc();
    rd_ack = 0; rd_data = '0;
  endtask

  task automatic boot(input logic [31:0] sp, input logic [31:0] pc, input int l1, input int l2);
    bus_grant = 1;
    serve(vec_addr(0), sp, l1);
    serve(vec_addr(1), pc, l2);
    chk(fetch_en == 1 && fetch_addr == pc, "R7", "fetch start", fetch_addr, pc);
    chk(sp_out == sp, "R5", "stack pointer", sp_out, sp);
    chk(pst == exp_pst(0, 0), "R7", "pst running", pst, exp_pst(0, 0));
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] sp, pc;
    void'($urandom(32'd1234));
    do_reset();

    // R4: no request without grant, or with another master active
    for (int i = 0; i < 4; i++) begin
      cyc(); #1;
      chk(!rd_req, "R4", "no grant", rd_req, 0);
    end
    bus_grant = 1; bus_alt_busy = 1;
    for (int i = 0; i < 3; i++) begin
      cyc(); #1;
      chk(!rd_req, "R4", "alt master", rd_req, 0);
    end
    bus_alt_busy = 0;
    boot(32'h0000_1000, 32'h0000_0400, 1, 2);

    // R9: fault while running, then handler start
    fault = 1; cyc(); fault = 0;
    chk(!fetch_en && pst == 4'hC, "R9", "exception entry", pst, 4'hC);
    cyc(); handler_start = 1; cyc(); handler_start = 0;
    chk(fetch_en && pst == 4'h0, "R9", "handler resumes", {fetch_en, pst}, 5'h10);

    // R10: nested fault halts and sticks
    fault = 1; cyc(); cyc();
    fault = 0;
    chk(pst == 4'hF && !fetch_en && !rd_req, "R10", "halt entry", pst, 4'hF);
    for (int i = 0; i < 20; i++) begin
      bus_grant = 1'($urandom); fault = 1'($urandom); handler_start = 1'($urandom);
      rd_ack = 1'($urandom);
      cyc(); #1;
      chk(pst == 4'hF && !fetch_en && !rd_req, "R10", "halt held", pst, 4'hF);
    end

    // R1: reset leaves halt
    do_reset();
    boot(32'hDEAD_0000, 32'h0000_2000, 0, 0);

    // R10: fault and handler_start in the same cycle during exception
    fault = 1; cyc();
    handler_start = 1; cyc(); fault = 0; handler_start = 0;
    chk(pst == 4'hF && !fetch_en, "R10", "collision halts", pst, 4'hF);

    // R8: grant lost before the second read
    do_reset();
    bus_grant = 1;
    serve(vec_addr(0), 32'h0000_5550, 0);
    bus_grant = 0;
    for (int i = 0; i < 3; i++) begin
      cyc(); #1;
      chk(!rd_req && !fetch_en, "R8", "paused", {rd_req, fetch_en}, 0);
    end
    chk(sp_out == 32'h0000_5550, "R8", "sp kept", sp_out, 32'h0000_5550);
    bus_grant = 1;
    serve(vec_addr(1), 32'h0000_0800, 1);
    chk(fetch_en && fetch_addr == 32'h0000_0800, "R8", "resumed pc", fetch_addr, 32'h0000_0800);

    // R8: alt master during the first read wait, no load
    do_reset();
    bus_grant = 1;
    cyc(); cyc(); #1;
    chk(rd_req && rd_addr == 0, "R8", "sp read issued", rd_addr, 0);
    bus_alt_busy = 1; cyc(); #1;
    chk(!rd_req, "R8", "dropped", rd_req, 0);
    cyc(); bus_alt_busy = 0;
    serve(vec_addr(0), 32'h0000_7770, 0);
    serve(vec_addr(1), 32'h0000_0100, 0);
    chk(sp_out == 32'h0000_7770 && fetch_en, "R8", "reissued sp", sp_out, 32'h0000_7770);

    // R11: fault during vector fetch halts
    do_reset();
    bus_grant = 1;
    cyc(); cyc(); #1;
    fault = 1; cyc(); fault = 0;
    chk(pst == 4'hF && !rd_req, "R11", "fault in fetch", pst, 4'hF);
    do_reset();
    fault = 1; cyc(); fault = 0;
    chk(pst == 4'hF, "R11", "fault in init", pst, 4'hF);

    // random boots
    for (int r = 0; r < 8; r++) begin
      do_reset();
      for (int w = 0; w < int'($urandom_range(0, 3)); w++) cyc();
      sp = $urandom; pc = $urandom & 32'hFFFF_FFFC;
      boot(sp, pc, int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
      for (int w = 0; w < int'($urandom_range(1, 5)); w++) begin
        cyc();
        chk(fetch_en && fetch_addr == pc, "R7", "stays running", fetch_addr, pc);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule